// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block is the part of an 8-bit processor core that decides what happens when an interrupt arrives. At each instruction boundary it looks at a pending non-maskable event and at the maskable request line. It then chooses one of three dispatch schemes and produces a single "jump target valid" pulse that carries the handler entry address. The core's decoder drives the software-controlled state through one-cycle strobes: enable, disable, mode select, vector-base load and return-from-NMI. The block holds the two interrupt-enable flip-flops, the dispatch mode and the vector-base register.

When a maskable request is accepted, the block raises an acknowledge strobe for one cycle and samples the byte a peripheral drives onto the data bus. In mode 0 that byte is decoded as a restart opcode. In mode 1 the byte is ignored and a fixed entry is used. In mode 2 the byte is joined under the vector-base register to form a table address, and the block reads a two-byte word from memory through a ready handshake. That word, and not the table address, is the handler entry.

Top module: `irq_resp_seq`

## Requirements
- R1: After reset the dispatch mode is 0, both enable flip-flops and the vector base are cleared, and int_ack_o, jump_valid_o, bad_op_o and mem_rd_o are low. A maskable request at a boundary is therefore not acknowledged.
- R2: A maskable request is accepted at a boundary when enabled. int_ack_o is then high for exactly the one cycle after that boundary edge. Acceptance clears both enables, and further requests get no acknowledge until software enables again.
- R3: An enable strobe takes effect at the next boundary. A request present at that boundary is not accepted; the earliest acceptance is at the following boundary.
- R4: A disable strobe clears both enables at once and cancels a pending enable.
- R5: In mode 0 the bus byte 11ttt111 (binary) produces jump_valid_o one cycle after the acknowledge cycle, with target ttt×8. When ack_driven_i is low the byte reads as 0xFF, which gives 0x0038.
- R6: In mode 0 any byte not of the form 11ttt111 pulses bad_op_o one cycle after the acknowledge cycle, and no jump is issued.
- R7: In mode 1 the target is 0x0038 one cycle after the acknowledge cycle, whatever the bus byte.
- R8: In mode 2 the table address is {vector base, bus byte}. The block reads the low byte at that address and then the high byte at the address plus one, modulo 2^16. Each read holds mem_rd_o and mem_addr_o until mem_rdy_i is seen. The target is {high, low}.
- R9: A rising edge on nmi_req_i is latched. At the next boundary it wins over any maskable request, whatever the enables are, and jump_valid_o carries 0x0066 one cycle later with no acknowledge. Its acceptance copies the main enable into the shadow enable and clears the main enable.
- R10: The return-from-NMI strobe copies the shadow enable back into the main enable.
- R11: The mode-select strobe accepts the values 0, 1 and 2. A value of 3 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction boundary; requests are sampled here |
| int_req_i | input | 1 | Maskable request, level |
| nmi_req_i | input | 1 | Non-maskable request, edge-detected |
| ack_byte_i | input | 8 | Byte a peripheral drives during acknowledge |
| ack_driven_i | input | 1 | Low when no peripheral drives the bus (reads 0xFF) |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| im_wr_i | input | 1 | Mode-select strobe |
| im_val_i | input | 2 | Mode value 0..2 |
| i_wr_i | input | 1 | Vector-base load strobe |
| i_val_i | input | 8 | Vector-base value |
| mem_data_i | input | 8 | Table read data |
| mem_rdy_i | input | 1 | Table read completes this cycle |
| int_ack_o | output | 1 | Maskable acknowledge strobe |
| mem_rd_o | output | 1 | Table read request |
| mem_addr_o | output | 16 | Table read address |
| jump_valid_o | output | 1 | Handler entry valid, one cycle |
| jump_addr_o | output | 16 | Handler entry address |
| bad_op_o | output | 1 | Mode-0 byte was not a restart opcode |

## Verification
A wrong enable flip-flop shows up at the next boundary that carries a request. The acknowledge either appears where it must not or is missing one cycle after that edge, so enable-timing faults are visible within one boundary. A wrong mode or vector-base value is seen one cycle after the acknowledge, as a wrong target address or as a stray bad-opcode pulse. A mode-2 fetch fault is seen in the order or address of the two memory reads, before the jump even appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_ACK, SEQ_FETCH} seq_state_e;
    typedef enum logic [1:0] {FT_IDLE, FT_LO, FT_HI} fetch_state_e;
    localparam logic [1:0] MODE_RST   = 2'd0;
    localparam logic [1:0] MODE_FIXED = 2'd1;
    localparam logic [1:0] MODE_TABLE = 2'd2;
endpackage

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              retn_i,
    input  logic              im_wr_i,
    input  logic [1:0]        im_val_i,
    input  logic              i_wr_i,
    input  logic [DATA_W-1:0] i_val_i,
    input  logic              take_int_i,
    input  logic              take_nmi_i,
    output logic              iff1_o,
    output logic [1:0]        im_o,
    output logic [DATA_W-1:0] ireg_o
);
    typedef struct packed {
        logic              iff1;
        logic              iff2;
        logic              ei_pend;
        logic [1:0]        im;
        logic [DATA_W-1:0] ireg;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (boundary_i && r_q.ei_pend) begin
            r_d.iff1    = 1'b1;
            r_d.iff2    = 1'b1;
            r_d.ei_pend = 1'b0;
        end
        if (ei_i) r_d.ei_pend = 1'b1;
        if (di_i) begin
            r_d.iff1    = 1'b0;
            r_d.iff2    = 1'b0;
            r_d.ei_pend = 1'b0;
        end
        if (retn_i) r_d.iff1 = r_q.iff2;
        if (im_wr_i && im_val_i != 2'd3) r_d.im = im_val_i;
        if (i_wr_i) r_d.ireg = i_val_i;
        if (take_nmi_i) begin
            r_d.iff2 = r_d.iff1;
            r_d.iff1 = 1'b0;
        end else if (take_int_i) begin
            r_d.iff1 = 1'b0;
            r_d.iff2 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign iff1_o = r_q.iff1;
    assign im_o   = r_q.im;
    assign ireg_o = r_q.ireg;

    AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_int_i |-> r_q.iff1); // R2
    AST_MASK_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take_int_i |=> (!r_q.iff1 && !r_q.iff2)); // R2
    AST_NMI_CLEARS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi_i |=> !r_q.iff1); // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.im != 2'd3); // R11
endmodule

// File: rtl/irq_rst_decode.sv
module irq_rst_decode #(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] op_i,
    output logic              valid_o,
    output logic [ADDR_W-1:0] target_o
);
    always_comb begin
        valid_o  = (op_i[7:6] == 2'b11) && (op_i[2:0] == 3'b111);
        target_o = '0;
        target_o[5:3] = op_i[5:3];
    end
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              mem_rdy_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] word_o
);
    typedef struct packed {
        fetch_state_e      st;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] lo;
        logic              done;
        logic [ADDR_W-1:0] word;
    } fetch_t;

    fetch_t f_q, f_d;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        unique case (f_q.st)
            FT_IDLE: if (start_i) begin
                f_d.st   = FT_LO;
                f_d.base = base_i;
            end
            FT_LO: if (mem_rdy_i) begin
                f_d.lo = mem_data_i;
                f_d.st = FT_HI;
            end
            FT_HI: if (mem_rdy_i) begin
                f_d.word = {mem_data_i, f_q.lo};
                f_d.done = 1'b1;
                f_d.st   = FT_IDLE;
            end
            default: f_d.st = FT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: FT_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign mem_rd_o   = (f_q.st != FT_IDLE);
    assign mem_addr_o = (f_q.st == FT_HI) ? f_q.base + ADDR_W'(1) : f_q.base;
    assign done_o     = f_q.done;
    assign word_o     = f_q.word;

    AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == FT_LO && mem_rdy_i) |=>
            (f_q.st == FT_HI && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R8
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o))); // R8
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (f_q.st == FT_IDLE)); // R8
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [2*DATA_W-1:0] NMI_ENTRY   = 16'h0066,
    parameter logic [2*DATA_W-1:0] FIXED_ENTRY = 16'h0038,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              int_req_i,
    input  logic              nmi_req_i,
    input  logic [DATA_W-1:0] ack_byte_i,
    input  logic              ack_driven_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              retn_i,
    input  logic              im_wr_i,
    input  logic [1:0]        im_val_i,
    input  logic              i_wr_i,
    input  logic [DATA_W-1:0] i_val_i,
    input  logic [DATA_W-1:0] mem_data_i,
    input  logic              mem_rdy_i,
    output logic              int_ack_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              jump_valid_o,
    output logic [ADDR_W-1:0] jump_addr_o,
    output logic              bad_op_o
);
    typedef struct packed {
        seq_state_e        state;
        logic              nmi_prev;
        logic              nmi_pend;
        logic              jv;
        logic [ADDR_W-1:0] jaddr;
        logic              bad;
    } seq_t;

    seq_t s_q, s_d;

    logic              bnd_take;
    logic              take_int, take_nmi, fetch_start;
    logic              iff1;
    logic [1:0]        mode;
    logic [DATA_W-1:0] ireg;
    logic [DATA_W-1:0] bus_byte;
    logic              rst_ok;
    logic [ADDR_W-1:0] rst_tgt;
    logic              fetch_done;
    logic [ADDR_W-1:0] fetch_word;

    assign bnd_take = boundary_i && (s_q.state == SEQ_IDLE);
    assign bus_byte = ack_driven_i ? ack_byte_i : '1;

    irq_state_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (bnd_take),
        .ei_i       (ei_i),
        .di_i       (di_i),
        .retn_i     (retn_i),
        .im_wr_i    (im_wr_i),
        .im_val_i   (im_val_i),
        .i_wr_i     (i_wr_i),
        .i_val_i    (i_val_i),
        .take_int_i (take_int),
        .take_nmi_i (take_nmi),
        .iff1_o     (iff1),
        .im_o       (mode),
        .ireg_o     (ireg)
    );

    irq_rst_decode #(.DATA_W(DATA_W)) u_dec (
        .op_i     (bus_byte),
        .valid_o  (rst_ok),
        .target_o (rst_tgt)
    );

    irq_vec_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (fetch_start),
        .base_i     ({ireg, bus_byte}),
        .mem_data_i (mem_data_i),
        .mem_rdy_i  (mem_rdy_i),
        .mem_rd_o   (mem_rd_o),
        .mem_addr_o (mem_addr_o),
        .done_o     (fetch_done),
        .word_o     (fetch_word)
    );

    always_comb begin
        s_d          = s_q;
        s_d.jv       = 1'b0;
        s_d.bad      = 1'b0;
        take_int     = 1'b0;
        take_nmi     = 1'b0;
        fetch_start  = 1'b0;
        s_d.nmi_prev = nmi_req_i;
        if (nmi_req_i && !s_q.nmi_prev) s_d.nmi_pend = 1'b1;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (bnd_take) begin
                    if (s_q.nmi_pend) begin
                        take_nmi     = 1'b1;
                        s_d.nmi_pend = nmi_req_i && !s_q.nmi_prev;
                        s_d.jv       = 1'b1;
                        s_d.jaddr    = NMI_ENTRY;
                    end else if (int_req_i && iff1) begin
                        take_int  = 1'b1;
                        s_d.state = SEQ_ACK;
                    end
                end
            end
            SEQ_ACK: begin
                s_d.state = SEQ_IDLE;
                if (mode == MODE_RST) begin
                    if (rst_ok) begin
                        s_d.jv    = 1'b1;
                        s_d.jaddr = rst_tgt;
                    end else begin
                        s_d.bad = 1'b1;
                    end
                end else if (mode == MODE_FIXED) begin
                    s_d.jv    = 1'b1;
                    s_d.jaddr = FIXED_ENTRY;
                end else begin
                    fetch_start = 1'b1;
                    s_d.state   = SEQ_FETCH;
                end
            end
            SEQ_FETCH: begin
                if (fetch_done) begin
                    s_d.jv    = 1'b1;
                    s_d.jaddr = fetch_word;
                    s_d.state = SEQ_IDLE;
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign int_ack_o    = (s_q.state == SEQ_ACK);
    assign jump_valid_o = s_q.jv;
    assign jump_addr_o  = s_q.jaddr;
    assign bad_op_o     = s_q.bad;

    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_take && s_q.nmi_pend) |=> (jump_valid_o && jump_addr_o == NMI_ENTRY)); // R9
    AST_NMI_BEFORE_INT: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_take && s_q.nmi_pend) |=> !int_ack_o); // R9
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |=> !int_ack_o); // R2
    AST_FIXED_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack_o && mode == MODE_FIXED) |=> (jump_valid_o && jump_addr_o == FIXED_ENTRY)); // R7
    AST_BAD_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op_o |-> !jump_valid_o); // R6
    AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (s_q.state == SEQ_FETCH)); // R8
endmodule

// File: tb/irq_resp_seq_test.sv
module irq_resp_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 0, int_req_i = 0, nmi_req_i = 0;
    logic [7:0]  ack_byte_i = 8'h00;
    logic        ack_driven_i = 1'b1;
    logic        ei_i = 0, di_i = 0, retn_i = 0, im_wr_i = 0, i_wr_i = 0;
    logic [1:0]  im_val_i = 2'd0;
    logic [7:0]  i_val_i = 8'h00;
    logic [7:0]  mem_data_i = 8'h00;
    logic        mem_rdy_i = 1'b0;
    logic        int_ack_o, mem_rd_o, jump_valid_o, bad_op_o;
    logic [15:0] mem_addr_o, jump_addr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] rd_log [256];
    logic [7:0]  nlog = 8'd0;
    int          wcnt = 0;

    always #2 clk = ~clk;

    irq_resp_seq uut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .int_req_i(int_req_i),
        .nmi_req_i(nmi_req_i), .ack_byte_i(ack_byte_i), .ack_driven_i(ack_driven_i),
        .ei_i(ei_i), .di_i(di_i), .retn_i(retn_i), .im_wr_i(im_wr_i), .im_val_i(im_val_i),
        .i_wr_i(i_wr_i), .i_val_i(i_val_i), .mem_data_i(mem_data_i), .mem_rdy_i(mem_rdy_i),
        .int_ack_o(int_ack_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .jump_valid_o(jump_valid_o), .jump_addr_o(jump_addr_o), .bad_op_o(bad_op_o)
    );

    function automatic logic [7:0] mem_val(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
    endfunction

    // memory model with random wait states; logs each granted address
    always @(negedge clk) begin
        if (rst_n && mem_rd_o) begin
            if (wcnt == 0) begin
                mem_rdy_i  <= 1'b1;
                mem_data_i <= mem_val(mem_addr_o);
                rd_log[nlog] = mem_addr_o;
                nlog = nlog + 8'd1;
                wcnt <= int'($urandom % 4);
            end else begin
                mem_rdy_i <= 1'b0;
                wcnt <= wcnt - 1;
            end
        end else begin
            mem_rdy_i <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic strobe_ei();   ei_i = 1;   step(); ei_i = 0;   endtask
    task automatic strobe_di();   di_i = 1;   step(); di_i = 0;   endtask
    task automatic strobe_retn(); retn_i = 1; step(); retn_i = 0; endtask
    task automatic set_mode(input logic [1:0] m);
        im_val_i = m; im_wr_i = 1; step(); im_wr_i = 0;
    endtask
    task automatic set_base(input logic [7:0] v);
        i_val_i = v; i_wr_i = 1; step(); i_wr_i = 0;
    endtask
    task automatic bnd();
        boundary_i = 1; step(); boundary_i = 0;
    endtask
    task automatic nmi_edge();
        nmi_req_i = 1; step(); nmi_req_i = 0; step();
    endtask

    // returns cycles waited, -1 on timeout
    task automatic wait_jump(output int n);
        n = -1;
        for (int k = 0; k < 100; k++) begin
            if (jump_valid_o) begin n = k; break; end
            step();
        end
    endtask

    // enable, let it take effect, then present a request at the next boundary
    task automatic arm_and_take(input string req);
        int_req_i = 0;
        strobe_ei();
        bnd();
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b1, req, {31'd0, int_ack_o}, 32'd1);
        int_req_i = 0;
    endtask

    task automatic check_table(input logic [7:0] ib, input logic [7:0] b, input string req);
        logic [15:0] ta;
        logic [7:0]  l0;
        int n;
        ta = {ib, b};
        l0 = nlog;
        step();
        wait_jump(n);
        check(n >= 0 && jump_addr_o === {mem_val(ta + 16'd1), mem_val(ta)}, req,
              {16'd0, jump_addr_o}, {16'd0, mem_val(ta + 16'd1), mem_val(ta)});
        check(rd_log[l0] === ta && rd_log[l0 + 8'd1] === ta + 16'd1, req,
              {rd_log[l0], rd_log[l0 + 8'd1]}, {ta, ta + 16'd1});
    endtask

    initial begin
        #(4 * 190000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) step();
        rst_n = 1;
        step();

        // R1: reset state
        check(!int_ack_o && !jump_valid_o && !bad_op_o && !mem_rd_o, "R1 outputs",
              {28'd0, int_ack_o, jump_valid_o, bad_op_o, mem_rd_o}, 32'd0);
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b0, "R1 disabled after reset", {31'd0, int_ack_o}, 32'd0);
        int_req_i = 0;

        // R3: EI effect delayed one boundary
        strobe_ei();
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b0, "R3 not at first boundary", {31'd0, int_ack_o}, 32'd0);
        ack_byte_i = 8'hD7; ack_driven_i = 1;
        bnd();
        check(int_ack_o === 1'b1, "R3 accepted at next boundary", {31'd0, int_ack_o}, 32'd1);
        step();
        check(int_ack_o === 1'b0, "R2 ack one cycle", {31'd0, int_ack_o}, 32'd0);
        // R1 mode 0 from reset, R5 decode 0xD7 -> 0x0010
        check(jump_valid_o && jump_addr_o === 16'h0010, "R5 restart D7",
              {16'd0, jump_addr_o}, 32'h0010);
        bnd();
        check(int_ack_o === 1'b0, "R2 masked after accept", {31'd0, int_ack_o}, 32'd0);
        int_req_i = 0;

        // R4: DI clears at once
        strobe_ei();
        bnd();
        strobe_di();
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b0, "R4 disabled", {31'd0, int_ack_o}, 32'd0);
        int_req_i = 0;
        // R4: DI cancels a pending enable
        strobe_ei();
        strobe_di();
        bnd();
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b0, "R4 pending cancelled", {31'd0, int_ack_o}, 32'd0);
        int_req_i = 0;

        // R5: undriven bus reads FF -> 0x0038
        ack_driven_i = 0;
        arm_and_take("R5 ack");
        step();
        check(jump_valid_o && jump_addr_o === 16'h0038, "R5 undriven",
              {16'd0, jump_addr_o}, 32'h0038);
        ack_driven_i = 1;

        // R6: unsupported byte
        ack_byte_i = 8'h3E;
        arm_and_take("R6 ack");
        step();
        check(bad_op_o === 1'b1 && jump_valid_o === 1'b0, "R6 bad byte",
              {30'd0, bad_op_o, jump_valid_o}, 32'd2);

        // R11: mode 3 ignored; R7: mode 1 fixed entry with a bad mode-0 byte
        set_mode(2'd1);
        set_mode(2'd3);
        ack_byte_i = 8'h00;
        arm_and_take("R7 ack");
        step();
        check(jump_valid_o && jump_addr_o === 16'h0038 && !bad_op_o, "R11 R7 mode1 kept",
              {15'd0, bad_op_o, jump_addr_o}, 32'h0038);

        // R8: table fetch, with address wrap
        set_mode(2'd2);
        set_base(8'hFF);
        ack_byte_i = 8'hFF;
        arm_and_take("R8 ack wrap");
        check_table(8'hFF, 8'hFF, "R8 wrap");
        set_base(8'h12);
        ack_byte_i = 8'h34;
        arm_and_take("R8 ack");
        check_table(8'h12, 8'h34, "R8 table");

        // R9: NMI wins over a maskable request, no ack
        set_mode(2'd0);
        ack_byte_i = 8'hFF;
        strobe_ei();
        bnd();
        nmi_edge();
        int_req_i = 1;
        bnd();
        check(jump_valid_o && jump_addr_o === 16'h0066 && !int_ack_o, "R9 nmi priority",
              {15'd0, int_ack_o, jump_addr_o}, 32'h0066);
        bnd();
        check(int_ack_o === 1'b0, "R9 main enable cleared", {31'd0, int_ack_o}, 32'd0);
        // R10: return restores from shadow (was enabled)
        strobe_retn();
        bnd();
        check(int_ack_o === 1'b1, "R10 restored", {31'd0, int_ack_o}, 32'd1);
        int_req_i = 0;
        step();
        // NMI accepted with enables clear; return keeps them clear
        nmi_edge();
        bnd();
        check(jump_valid_o && jump_addr_o === 16'h0066, "R9 nmi while disabled",
              {16'd0, jump_addr_o}, 32'h0066);
        strobe_retn();
        int_req_i = 1;
        bnd();
        check(int_ack_o === 1'b0, "R10 shadow clear", {31'd0, int_ack_o}, 32'd0);
        int_req_i = 0;

        // random mix of modes, bytes, bases
        for (int it = 0; it < 40; it++) begin
            logic [1:0] m;
            logic [7:0] b, ib, eb;
            m = 2'($urandom % 3);
            b = 8'($urandom);
            if (($urandom % 3) == 0) b = {2'b11, b[5:3], 3'b111};
            ib = 8'($urandom);
            ack_driven_i = ($urandom % 4) != 0;
            eb = ack_driven_i ? b : 8'hFF;
            ack_byte_i = b;
            set_mode(m);
            set_base(ib);
            arm_and_take("R2 random ack");
            if (m == 2'd2) begin
                check_table(ib, eb, "R8 random");
            end else begin
                step();
                if (m == 2'd1)
                    check(jump_valid_o && jump_addr_o === 16'h0038, "R7 random",
                          {16'd0, jump_addr_o}, 32'h0038);
                else if (eb[7:6] == 2'b11 && eb[2:0] == 3'b111)
                    check(jump_valid_o && jump_addr_o === {10'd0, eb[5:3], 3'd0}, "R5 random",
                          {16'd0, jump_addr_o}, {26'd0, eb[5:3], 3'd0});
                else
                    check(bad_op_o && !jump_valid_o, "R6 random",
                          {30'd0, bad_op_o, jump_valid_o}, 32'd2);
            end
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule